// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital control for one synchronous buck phase. It takes the modulator's PWM request and decides, cycle by cycle, when the high-side and low-side gate commands are raised. It protects against shoot-through adaptively. A gate may turn on only after the opposite gate has been sensed below its threshold, and that sensed-low flag must then hold for a minimum number of clock cycles. If the falling gate lingers above the threshold, the dead time grows to match.

A mode input selects between two ways of running the low side. In forced continuous conduction the low side stays on for the whole off-portion of the switching period, so negative inductor current is allowed. In diode emulation a zero-current comparator ends low-side conduction early, and both gates then stay off until the next high-side request.

The analog drivers and the comparators lie outside the block. Their results arrive as synchronous digital inputs.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after `enable` is sampled low, both `hs_gate` and `ls_gate` are 0.
- R2: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R3: `hs_gate` rises only after `ls_low` has been sampled 1 on DEAD_CYC consecutive edges while the high side is pending. A 0 on `ls_low` restarts the count, and the count begins on the edge after the pending state is entered.
- R4: `ls_gate` rises only after `hs_low` has been sampled 1 on DEAD_CYC consecutive edges while the low side is pending, with the same restart rule as R3.
- R5: If `pwm_req` is sampled 1 while `ls_gate` is 1, `ls_gate` drops on that edge. `hs_gate` then waits for the R3 condition.
- R6: With `ccm_force` = 1, `ls_gate` stays 1 for as long as `pwm_req` is 0, whatever `zero_cross` does.
- R7: With `ccm_force` = 0, a `zero_cross` = 1 sampled while `ls_gate` is 1 and `pwm_req` is 0 drops `ls_gate` on that edge. Both gates then stay 0 until `pwm_req` is sampled 1.
- R8: `zero_cross` has no effect while `hs_gate` is 1. The high side stays on for as long as `pwm_req` is 1.
- R9: If `pwm_req` is sampled 0 while the high side is still pending, the request is abandoned: `hs_gate` stays 0 and the low side becomes pending under R4.
- R10: On the first enabled edge after reset or disable, `pwm_req` = 1 makes the high side pending and `pwm_req` = 0 makes the low side pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Phase enable; 0 forces both gates off |
| pwm_req | input | 1 | Modulator request: 1 = high-side on-time |
| ccm_force | input | 1 | 1 = forced continuous conduction, 0 = diode emulation |
| hs_low | input | 1 | High-side gate sensed below threshold |
| ls_low | input | 1 | Low-side gate sensed below threshold |
| zero_cross | input | 1 | Inductor current has reached zero |
| hs_gate | output | 1 | High-side gate-on command |
| ls_gate | output | 1 | Low-side gate-on command |

## Verification
Both gate outputs are registered. Any decision taken on an edge is visible one edge after the inputs were applied, so turning a gate off costs one cycle. Turning a gate on costs one edge to enter the pending state, plus DEAD_CYC edges with the opposite sensed-low flag held. The bench applies inputs on the falling clock edge and compares at the next falling edge against a cycle model that advances once per rising edge. Its directed sequences test the exact edge on which each gate must still be 0 and the edge on which it must first be 1.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

   typedef enum logic [2:0] {
      PH_OFF     = 3'd0,
      PH_HS_WAIT = 3'd1,
      PH_HS_ON   = 3'd2,
      PH_LS_WAIT = 3'd3,
      PH_LS_ON   = 3'd4,
      PH_PARK    = 3'd5
   } phase_e;

   localparam int SIDE_HS = 0;
   localparam int SIDE_LS = 1;
   localparam int N_SIDES = 2;

endpackage

// File: rtl/buck_dead_timer.sv
module buck_dead_timer #(
   parameter int DEAD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic arm,
   output logic done
);
   localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

   logic [CW-1:0] cnt;

   assign done = arm && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr || !arm || done) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/buck_phase_fsm.sv
module buck_phase_fsm
   import buck_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pwm_req,
   input  logic ccm_force,
   input  logic hs_low,
   input  logic ls_low,
   input  logic zero_cross,
   input  logic hs_done,
   input  logic ls_done,
   output logic hs_clr,
   output logic ls_clr,
   output logic hs_gate,
   output logic ls_gate
);
   phase_e cur, nxt;

   always_comb begin
      nxt = cur;
      if (!enable) begin
         nxt = PH_OFF;
      end else begin
         unique case (cur)
            PH_OFF:     nxt = pwm_req ? PH_HS_WAIT : PH_LS_WAIT;
            PH_HS_WAIT: if (!pwm_req)     nxt = PH_LS_WAIT;
                        else if (hs_done) nxt = PH_HS_ON;
            PH_HS_ON:   if (!pwm_req)     nxt = PH_LS_WAIT;
            PH_LS_WAIT: if (pwm_req)      nxt = PH_HS_WAIT;
                        else if (ls_done) nxt = PH_LS_ON;
            PH_LS_ON:   if (pwm_req)      nxt = PH_HS_WAIT;
                        else if (!ccm_force && zero_cross) nxt = PH_PARK;
            PH_PARK:    if (pwm_req)      nxt = PH_HS_WAIT;
            default:    nxt = PH_OFF;
         endcase
      end
   end

   assign hs_clr = (cur != PH_HS_WAIT) || (nxt != cur);
   assign ls_clr = (cur != PH_LS_WAIT) || (nxt != cur);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur     <= PH_OFF;
         hs_gate <= 1'b0;
         ls_gate <= 1'b0;
      end else begin
         cur     <= nxt;
         hs_gate <= (nxt == PH_HS_ON);
         ls_gate <= (nxt == PH_LS_ON);
      end
   end

   // R2
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));
   // R1
   disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!hs_gate && !ls_gate));
   // R3
   hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> ($past(ls_low) && !$past(ls_gate)));
   // R4
   ls_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate) |-> ($past(hs_low) && !$past(hs_gate)));
   // R5
   pwm_cuts_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_req && ls_gate) |=> (!ls_gate && !hs_gate));
   // R6
   ccm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && ccm_force && !pwm_req && ls_gate) |=> ls_gate);
   // R7
   dem_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !ccm_force && zero_cross && !pwm_req && ls_gate) |=> !ls_gate);
   // R8
   hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && pwm_req && hs_gate) |=> hs_gate);
   // R9
   hs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_req |=> !hs_gate);

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
   import buck_gate_pkg::*;
#(
   parameter int DEAD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pwm_req,
   input  logic ccm_force,
   input  logic hs_low,
   input  logic ls_low,
   input  logic zero_cross,
   output logic hs_gate,
   output logic ls_gate
);
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end

   logic [N_SIDES-1:0] t_clr, t_arm, t_done;

   // each side waits on the opposite gate's sensed-low flag
   assign t_arm[SIDE_HS] = ls_low;
   assign t_arm[SIDE_LS] = hs_low;

   for (genvar s = 0; s < N_SIDES; s++) begin : g_side
      buck_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (t_clr[s]),
         .arm  (t_arm[s]),
         .done (t_done[s])
      );
   end

   buck_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .pwm_req   (pwm_req),
      .ccm_force (ccm_force),
      .hs_low    (hs_low),
      .ls_low    (ls_low),
      .zero_cross(zero_cross),
      .hs_done   (t_done[SIDE_HS]),
      .ls_done   (t_done[SIDE_LS]),
      .hs_clr    (t_clr[SIDE_HS]),
      .ls_clr    (t_clr[SIDE_LS]),
      .hs_gate   (hs_gate),
      .ls_gate   (ls_gate)
   );

endmodule

// File: tb/buck_gate_sequencer_tb.sv
module buck_gate_sequencer_tb;
   localparam int DT = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 1'b0, pwm_req = 1'b0, ccm_force = 1'b1;
   logic hs_low = 1'b1, ls_low = 1'b1, zero_cross = 1'b0;
   logic hs_gate, ls_gate;

   int n_chk = 0, n_bad = 0;
   int m_ph = 0, m_cnt = 0;   // 0 off,1 hs pending,2 hs on,3 ls pending,4 ls on,5 parked

   always #10 clk = ~clk;

   buck_gate_sequencer #(.DEAD_CYC(DT)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_req(pwm_req),
      .ccm_force(ccm_force), .hs_low(hs_low), .ls_low(ls_low),
      .zero_cross(zero_cross), .hs_gate(hs_gate), .ls_gate(ls_gate));

   function automatic bit exp_hs(); return m_ph == 2; endfunction
   function automatic bit exp_ls(); return m_ph == 4; endfunction

   task automatic check(string tag, logic got, logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_step();
      int nph = m_ph, ncnt = 0;
      if (!rst_n || !enable) nph = 0;
      else case (m_ph)
         0: nph = pwm_req ? 1 : 3;
         1: if (!pwm_req) nph = 3;
            else if (ls_low) begin
               if (m_cnt == DT-1) nph = 2; else ncnt = m_cnt + 1;
            end
         2: if (!pwm_req) nph = 3;
         3: if (pwm_req) nph = 1;
            else if (hs_low) begin
               if (m_cnt == DT-1) nph = 4; else ncnt = m_cnt + 1;
            end
         4: if (pwm_req) nph = 1;
            else if (!ccm_force && zero_cross) nph = 5;
         5: if (pwm_req) nph = 1;
         default: nph = 0;
      endcase
      m_ph = nph; m_cnt = ncnt;
   endtask

   // drive at negedge, one rising edge, compare at next negedge
   task automatic st(bit en, bit pwm, bit ccm, bit hl, bit ll, bit zc);
      enable = en; pwm_req = pwm; ccm_force = ccm;
      hs_low = hl; ls_low = ll; zero_cross = zc;
      model_step();
      @(posedge clk); @(negedge clk);
      check("R2 overlap", hs_gate & ls_gate, 1'b0);
      check("model hs (R3 R5 R8 R9)", hs_gate, exp_hs());
      check("model ls (R4 R6 R7)", ls_gate, exp_ls());
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1 reset hs", hs_gate, 1'b0);
      check("R1 reset ls", ls_gate, 1'b0);
      rst_n = 1'b1;

      // R10 / R4: low side pending from start, DT edges after entry
      repeat (3) st(1,0,1,1,1,0);
      check("R4 ls before dead time", ls_gate, 1'b0);
      st(1,0,1,1,1,0);
      check("R10 ls on from start", ls_gate, 1'b1);
      // R6: zero cross ignored in forced continuous mode
      repeat (5) st(1,0,1,1,1,1);
      check("R6 ls held", ls_gate, 1'b1);
      // R5: request while low side on
      st(1,1,1,0,0,0);
      check("R5 ls cut", ls_gate, 1'b0);
      check("R5 hs waits", hs_gate, 1'b0);
      repeat (2) st(1,1,1,0,0,0);
      check("R3 hs waits for ls_low", hs_gate, 1'b0);
      repeat (2) st(1,1,1,0,1,0);
      check("R3 hs before dead time", hs_gate, 1'b0);
      st(1,1,1,0,1,0);
      check("R3 hs on", hs_gate, 1'b1);
      // R8
      repeat (4) st(1,1,0,1,1,1);
      check("R8 hs ignores zero cross", hs_gate, 1'b1);
      // R7 diode emulation
      repeat (4) st(1,0,0,1,1,0);
      check("R7 ls on", ls_gate, 1'b1);
      st(1,0,0,1,1,1);
      check("R7 ls cut at zero", ls_gate, 1'b0);
      repeat (4) st(1,0,0,1,1,0);
      check("R7 parked ls", ls_gate, 1'b0);
      check("R7 parked hs", hs_gate, 1'b0);
      // R9 abandoned high-side request
      repeat (2) st(1,1,0,1,1,0);
      st(1,0,0,1,1,0);
      check("R9 hs never on", hs_gate, 1'b0);
      repeat (2) st(1,0,0,1,1,0);
      check("R9 ls pending", ls_gate, 1'b0);
      st(1,0,0,1,1,0);
      check("R9 ls on", ls_gate, 1'b1);
      // R4 count restart
      st(1,1,1,1,1,0);
      st(1,0,1,1,1,0);
      repeat (2) st(1,0,1,1,1,0);
      st(1,0,1,0,1,0);
      repeat (2) st(1,0,1,1,1,0);
      check("R4 restart holds ls off", ls_gate, 1'b0);
      st(1,0,1,1,1,0);
      check("R4 ls on after restart", ls_gate, 1'b1);
      // R1 disable, R10 restart with high request
      st(0,1,1,1,1,0);
      check("R1 disable hs", hs_gate, 1'b0);
      check("R1 disable ls", ls_gate, 1'b0);
      repeat (3) st(1,1,1,1,1,0);
      check("R10 hs before dead time", hs_gate, 1'b0);
      st(1,1,1,1,1,0);
      check("R10 hs on from start", hs_gate, 1'b1);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         bit en  = ($urandom_range(0, 99) < 97);
         bit pwm = (($urandom_range(0, 5) == 0) ? ~pwm_req : pwm_req);
         bit ccm = (($urandom_range(0, 49) == 0) ? ~ccm_force : ccm_force);
         bit hl  = ($urandom_range(0, 3) != 0);
         bit ll  = ($urandom_range(0, 3) != 0);
         bit zc  = ($urandom_range(0, 9) < 3);
         st(en, pwm, ccm, hl, ll, zc);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule